// File: doc/BRIEF.md
# Eight-Input Prioritized Interrupt Controller

This block gathers eight interrupt request lines and presents them to a small processor through a four-location register bus. Each line can be set to be sensitive to a rising edge or to a level. Requests pass through a synchronizer and are held in a pending register. A fixed-priority encoder picks the lowest-numbered pending line and reports its index. A combined active-high interrupt output is raised whenever any line is pending.

Software clears requests only through read side effects. Reading the vector location returns the index of the top request and clears that one request. Reading the clear-all location clears every edge-triggered request. A level-triggered request is never cleared by software: its pending bit follows its synchronized input.

A small bus state machine makes sure each read strobe has its side effect only once, however long the strobe is held. It has two states. BUS_IDLE waits for a strobe. The transition IDLE->HELD is taken when the read strobe is seen: the read data is captured and the side effect fires on that edge. BUS_HELD waits for the strobe to drop. The transition HELD->IDLE is taken when the read strobe is low. In every other case the machine stays in its current state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the sense register, the pending register, the read data and `irq_out` are all 0.
- R2: Address 0 holds the sense register and can be written and read back. Bit n = 1 makes input n level sensitive. Bit n = 0 makes input n rising-edge sensitive.
- R3: A rising edge on an edge-sensitive input sets its pending bit. The bit is visible three clocks after the input changes and stays set after the input falls.
- R4: Reading address 1 returns the pending bits, with bit n for input n. The read has no side effect.
- R5: The pending bit of a level-sensitive input follows the synchronized input. Reads of address 2 and address 3 do not clear it.
- R6: Reading address 3 returns the pending bits as they were before the read, then clears every edge-sensitive pending bit.
- R7: A rising edge detected in the same cycle as a clear stays pending.
- R8: Reading address 2 returns the index of the lowest-numbered pending input in bits 2:0, with bits 7:3 reading 0. It returns 0 when nothing is pending. The read then clears that one request if it is edge sensitive.
- R9: `irq_out` is 1 exactly when at least one pending bit is set.
- R10: A read strobe held high for several cycles causes its side effect once.
- R11: Writes to addresses 1, 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Asynchronous request lines, bit n is input n |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, updated on the clock edge where a read strobe starts |
| irq_out | output | 1 | High while any request is pending |

## Verification
The assertions assume that the request lines are the only asynchronous inputs. They also assume that the bus signals are stable around each rising clock edge and that a read strobe stays low for at least one cycle between reads. The stimulus drives every input on the falling edge and leaves an idle cycle after each read. It holds request pulses for at least one full clock, so the synchronizer always sees them. The same-cycle clear case is produced by timing the clear-all strobe to reach the edge where a new rising edge is detected.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        A_SENSE  = 2'd0,
        A_PEND   = 2'd1,
        A_VECT   = 2'd2,
        A_CLRALL = 2'd3
    } reg_addr_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_i,
    input  logic [N_SRC-1:0] sense_i,
    input  logic             clr_all_i,
    input  logic [N_SRC-1:0] ack_mask_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] pend_d;

    assign rise = sync_i & ~prev_q;

    generate
        for (genvar n = 0; n < N_SRC; n++) begin : g_bit
            always_comb begin
                if (sense_i[n]) pend_d[n] = sync_i[n];
                else pend_d[n] = rise[n] | (pend_q[n] & ~(clr_all_i | ack_mask_i[n]));
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= sync_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R5: a level-mode bit follows the synchronized input one clock later
    a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q & $past(sense_i)) == ($past(sync_i) & $past(sense_i)));

    // R6: after a clear-all only new edges remain among edge-mode bits
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (pend_q & ~$past(sense_i) & ~$past(rise)) == '0);

    // R7: a detected edge is never lost, even with a clear in the same cycle
    a_r7_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~sense_i) != '0) |=> (($past(rise & ~sense_i)) & ~pend_q) == '0);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned VEC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             any_o
);
    always_comb begin
        vec_o = '0;
        any_o = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vec_o = VEC_W'(i);
                any_o = 1'b1;
            end
        end
    end

    // R8: the reported index is pending
    a_r8_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[vec_o]);

    // R8: no lower-numbered input is pending
    a_r8_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (pend_i & ((N_SRC'(1) << vec_o) - N_SRC'(1))) == '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC       = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int unsigned VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    bus_state_e        state_q, state_d;
    logic [N_SRC-1:0]  sense_q;
    logic [N_SRC-1:0]  sync_w;
    logic [N_SRC-1:0]  pend_w;
    logic [VEC_W-1:0]  vec_w;
    logic              any_w;
    logic              rd_start;
    logic              clr_all;
    logic              ack_fire;
    logic [N_SRC-1:0]  ack_mask;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    irqc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_in), .sync_o(sync_w)
    );

    irqc_pending #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .sense_i(sense_q),
        .clr_all_i(clr_all), .ack_mask_i(ack_mask), .pend_o(pend_w)
    );

    irqc_prio #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .vec_o(vec_w), .any_o(any_w)
    );

    // bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_rd)  state_d = BUS_HELD;
            BUS_HELD: if (!bus_rd) state_d = BUS_IDLE;
            default:               state_d = BUS_IDLE;
        endcase
    end

    // outputs of the bus machine: one-shot side effects
    always_comb begin
        rd_start = (state_q == BUS_IDLE) && bus_rd;
        clr_all  = rd_start && (bus_addr == A_CLRALL);
        ack_fire = rd_start && (bus_addr == A_VECT) && any_w;
        ack_mask = '0;
        if (ack_fire) ack_mask[vec_w] = 1'b1;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_SENSE:  rd_mux[N_SRC-1:0] = sense_q;
            A_PEND:   rd_mux[N_SRC-1:0] = pend_w;
            A_VECT:   rd_mux[VEC_W-1:0] = vec_w;
            A_CLRALL: rd_mux[N_SRC-1:0] = pend_w;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            rdata_q <= '0;
        end else begin
            if (bus_wr && (bus_addr == A_SENSE)) sense_q <= bus_wdata[N_SRC-1:0];
            if (rd_start) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = any_w;

    // R10: a side effect never fires on two consecutive cycles
    a_r10_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all || ack_fire) |=> !(clr_all || ack_fire));

    // R8: reserved bits of the vector read are zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && bus_addr == A_VECT) |=> bus_rdata[DATA_W-1:VEC_W] == '0);

    // R11: the sense register moves only on a write to address 0
    a_r11_sense_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_SENSE) |=> $stable(sense_q));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;
    logic       mon_due = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: a read strobe starting at an edge yields data at the next falling edge
    always @(posedge clk) begin
        mon_due <= bus_rd && !rd_d;
        rd_d    <= bus_rd;
    end

    always @(negedge clk) begin
        if (mon_due) begin
            if (exp_q.size() == 0) chk(bus_rdata, 8'hxx, "unexpected read");
            else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag, input int hold = 1);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        repeat (hold) @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] bits);
        @(negedge clk);
        irq_in = irq_in | bits;
        @(negedge clk);
        irq_in = irq_in & ~bits;
        settle();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        chk({7'd0, irq_out}, {7'd0, e}, tag);
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b0, "R1 irq_out after reset");
        chk(bus_rdata, 8'h00, "R1 rdata after reset");
        rd(2'd0, 8'h00, "R1 sense reset");
        rd(2'd1, 8'h00, "R1 pending reset");
        rd(2'd2, 8'h00, "R8 vector with none pending");

        wr(2'd0, 8'hA5);
        rd(2'd0, 8'hA5, "R2 sense readback");
        wr(2'd0, 8'h00);

        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd0, 8'h00, "R11 sense untouched");
        rd(2'd1, 8'h00, "R11 pending untouched");

        pulse(8'h20);
        rd(2'd1, 8'h20, "R3 edge latched");
        chk_irq(1'b1, "R9 irq_out with pending");
        rd(2'd1, 8'h20, "R4 pending read no side effect");

        pulse(8'h42);
        rd(2'd2, 8'h01, "R8 top vector 1");
        rd(2'd1, 8'h60, "R8 ack cleared only bit 1");
        rd(2'd2, 8'h05, "R8 top vector 5");
        rd(2'd2, 8'h06, "R8 top vector 6");
        rd(2'd1, 8'h00, "R8 all acked");
        chk_irq(1'b0, "R9 irq_out idle");

        pulse(8'h0A);
        rd(2'd2, 8'h01, "R10 held vector read", 4);
        rd(2'd1, 8'h08, "R10 only one ack");
        rd(2'd3, 8'h08, "R6 clear-all returns prior");
        rd(2'd1, 8'h00, "R6 cleared");

        wr(2'd0, 8'h80);
        @(negedge clk);
        irq_in[7] = 1'b1;
        settle();
        pulse(8'h01);
        rd(2'd3, 8'h81, "R6 clear-all with level");
        rd(2'd1, 8'h80, "R5 level survives clear-all");
        rd(2'd2, 8'h07, "R5 vector to level source");
        rd(2'd1, 8'h80, "R5 level survives vector read");
        @(negedge clk);
        irq_in[7] = 1'b0;
        settle();
        rd(2'd1, 8'h00, "R5 level follows input");
        chk_irq(1'b0, "R9 irq_out after level drop");
        wr(2'd0, 8'h00);

        pulse(8'h10);
        @(negedge clk);
        irq_in[2] = 1'b1;
        @(negedge clk);
        rd(2'd3, 8'h10, "R7 clear-all before new edge");
        rd(2'd1, 8'h04, "R7 same-cycle edge kept");
        irq_in[2] = 1'b0;
        settle();
        rd(2'd3, 8'h04, "R7 final clear");
        rd(2'd1, 8'h00, "R6 empty at end");

        finish_run();
    end
endmodule